// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the two least significant address bits of a four-beat memory burst. When a new access starts, it captures the two low bits of the external address as the first beat. On each later clock cycle that has the advance input high, it moves to the next beat. The higher address bits bypass this block and come straight from the address register, so the sequencer only ever walks within an aligned group of four words.

A static select input sets the beat order. In linear order each beat adds one to the start value, modulo four. In interleaved order the beat count is XORed with the start value. The select input does not pass through any register. It is meant to be tied high or low, and the output follows it at once. A clock enable freezes the whole block.

Inside the block, a four-state machine tracks the beat count. Its states are BEAT0, BEAT1, BEAT2 and BEAT3. It has three kinds of transition. LOAD goes from any state to BEAT0. STEP goes from BEAT*k* to BEAT*k+1*. WRAP goes from BEAT3 to BEAT0. When the machine holds its state, it stays where it is. A separate register keeps the captured start bits. A combinational mapper turns the start bits, the beat count and the select input into the output.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active, and after it is released with no other input, the beat count is BEAT0, the stored start is 0 and `burst_addr` reads 0.
- R2: A rising clock edge with `ce`=1 and `load`=1 stores `start_addr`. From that edge `burst_addr` equals the stored start.
- R3: With `order_lin`=1 (linear), beat k gives `burst_addr` = (start + k) mod 4.
- R4: With `order_lin`=0 (interleaved), beat k gives `burst_addr` = start XOR k.
- R5: An advance from the fourth beat (BEAT3) goes back to BEAT0, so `burst_addr` returns to the stored start.
- R6: On an edge with `ce`=0, the beat count and the stored start keep their values, whatever `load`, `adv` and `start_addr` are.
- R7: When `load` and `adv` are both 1 with `ce`=1, the load wins: the new start is stored and the beat count becomes BEAT0.
- R8: On an edge with `ce`=1, `load`=0 and `adv`=0, `burst_addr` keeps its value.
- R9: `order_lin` is not registered. A change on it changes `burst_addr` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; when 0, all state holds |
| load | input | 1 | Starts a new access and captures `start_addr` |
| adv | input | 1 | Moves to the next burst beat |
| order_lin | input | 1 | Static order select: 1 linear, 0 interleaved |
| start_addr | input | 2 | Low two bits of the external address |
| burst_addr | output | 2 | Low two bits of the current beat address |

## Verification
`load`, `adv` and `ce` act at the next rising edge. Their effect shows on `burst_addr` after that edge, one cycle after the inputs were driven, because only the beat register and the start register lie on the path. `order_lin` has no register on its path, so its effect is checked a moment after it changes and before any edge. The driver task applies inputs after an edge and pushes the expected value once the next edge has passed. The monitor pops and compares at the following falling edge, so every sample lands half a period after the register update that produced it. The driver changes the order select only at a falling edge, after the queue has drained, so no expected value is pushed under one order and sampled under the other.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int unsigned BEAT_W = 2;
    localparam int unsigned BEATS  = 1 << BEAT_W;

    typedef enum logic [BEAT_W-1:0] {
        BEAT0 = 2'd0,
        BEAT1 = 2'd1,
        BEAT2 = 2'd2,
        BEAT3 = 2'd3
    } beat_e;
endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce,
    input  logic  load,
    input  logic  adv,
    output beat_e beat
);
    beat_e beat_d;

    // next-state logic: LOAD, STEP, WRAP or hold
    always_comb begin
        beat_d = beat;
        if (ce) begin
            if (load) begin
                beat_d = BEAT0;
            end else if (adv) begin
                unique case (beat)
                    BEAT0: beat_d = BEAT1;
                    BEAT1: beat_d = BEAT2;
                    BEAT2: beat_d = BEAT3;
                    BEAT3: beat_d = BEAT0;
                    default: beat_d = BEAT0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat <= BEAT0;
        else        beat <= beat_d;
    end

    assert_ce_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(beat));
    assert_load_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && load) |=> (beat == BEAT0));
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !load && adv && beat == BEAT3) |=> (beat == BEAT0));
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !load && adv && beat != BEAT3) |=> (beat != BEAT0));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
(
    input  logic [BEAT_W-1:0] start_q,
    input  beat_e             beat,
    input  logic              order_lin,
    output logic [BEAT_W-1:0] addr
);
    logic [BEAT_W-1:0] lin_addr;
    logic [BEAT_W-1:0] ilv_addr;

    always_comb begin
        lin_addr = start_q + BEAT_W'(beat);
        ilv_addr = start_q ^ BEAT_W'(beat);
        addr     = order_lin ? lin_addr : ilv_addr;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              load,
    input  logic              adv,
    input  logic              order_lin,
    input  logic [BEAT_W-1:0] start_addr,
    output logic [BEAT_W-1:0] burst_addr
);
    beat_e             beat;
    logic [BEAT_W-1:0] start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          start_q <= '0;
        else if (ce && load) start_q <= start_addr;
    end

    burst_beat_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .load  (load),
        .adv   (adv),
        .beat  (beat)
    );

    burst_addr_map u_map (
        .start_q   (start_q),
        .beat      (beat),
        .order_lin (order_lin),
        .addr      (burst_addr)
    );

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && load) |=> (burst_addr == $past(start_addr)));
    assert_linear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        order_lin |-> (BEAT_W'(burst_addr - start_q) == BEAT_W'(beat)));
    assert_interleave_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !order_lin |-> ((burst_addr ^ start_q) == BEAT_W'(beat)));
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !load && !adv && $stable(order_lin)) |=> $stable(burst_addr));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic       load = 1'b0;
    logic       adv = 1'b0;
    logic       order_lin = 1'b1;
    logic [1:0] start_addr = 2'd0;
    logic [1:0] burst_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic done = 1'b0;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    logic [1:0] m_start = 2'd0;
    logic [1:0] m_beat  = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen i_burst_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce         (ce),
        .load       (load),
        .adv        (adv),
        .order_lin  (order_lin),
        .start_addr (start_addr),
        .burst_addr (burst_addr)
    );

    function automatic logic [1:0] model_addr();
        return order_lin ? 2'(m_start + m_beat) : (m_start ^ m_beat);
    endfunction

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: apply inputs, let one edge pass, push the expected result
    task automatic step(input logic c, input logic l, input logic a,
                        input logic [1:0] s, input string tag);
        ce = c; load = l; adv = a; start_addr = s;
        @(posedge clk);
        #1;
        if (c) begin
            if (l) begin m_start = s; m_beat = 2'd0; end
            else if (a) m_beat = m_beat + 2'd1;
        end
        sb.push_back('{model_addr(), tag});
    endtask

    task automatic set_order(input logic v);
        @(negedge clk);
        #1;
        order_lin = v;
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(burst_addr, it.exp, it.tag);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD*2);
        check(burst_addr, 2'd0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b0, 2'd0, "R1 after reset");

        // linear bursts
        step(1'b1, 1'b1, 1'b0, 2'd1, "R2 load start 1");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R3 linear beat1");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R3 linear beat2");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R3 linear beat3");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R5 linear wrap");
        step(1'b1, 1'b0, 1'b0, 2'd2, "R8 idle hold");
        step(1'b0, 1'b1, 1'b1, 2'd3, "R6 ce low ignores load/adv");
        step(1'b1, 1'b1, 1'b1, 2'd3, "R7 load beats adv");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R3 linear from 3");

        // interleaved bursts
        set_order(1'b0);
        step(1'b1, 1'b1, 1'b0, 2'd1, "R2 load start 1 ilv");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R4 ilv beat1");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R4 ilv beat2");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R4 ilv beat3");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R5 ilv wrap");
        step(1'b1, 1'b1, 1'b0, 2'd2, "R2 load start 2 ilv");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R4 ilv start2 beat1");
        step(1'b0, 1'b0, 1'b1, 2'd0, "R6 ce low ignores adv");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R4 ilv start2 beat2");

        // order select without a clock edge, at beat1 of start 1
        step(1'b1, 1'b1, 1'b0, 2'd1, "R2 load start 1 for R9");
        step(1'b1, 1'b0, 1'b1, 2'd0, "R4 beat1 for R9");
        ce = 1'b0; adv = 1'b0;
        @(negedge clk);
        #1;
        order_lin = 1'b1;
        #1;
        check(burst_addr, 2'd2, "R9 switch to linear");
        order_lin = 1'b0;
        #1;
        check(burst_addr, 2'd0, "R9 switch to interleaved");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule